// File: doc/BRIEF.md
# Packed Saturating and Halving Arithmetic Unit

This unit performs packed integer arithmetic on a 32-bit word in which the raw sum or difference is never returned as is. Depending on the operation code, each 8-bit or 16-bit lane is either clamped to its representable range or divided by two. The clamp can be signed or unsigned. The division by two takes one bit more than the lane width, so it cannot overflow. A second group works on whole 32-bit signed words. It offers saturating add and subtract, plus doubling variants that first clamp twice the second operand and then add it or subtract it.

The operation is computed combinationally. The result is captured on the clock edge where `valid_i` is high and appears on `res_o` one cycle later. A 32-bit operation that clamps at any step raises `sat_o` together with its result. It also sets a sticky flag, `q_o`, which only a reset or the clear input brings back low. Lane operations never report saturation and never change the sticky flag.

Operation code `op_i` (6 bits). When bit 5 is 0, a lane operation is selected:
- bits 4:3 select the class: 00 signed saturate, 01 unsigned saturate, 10 signed halve, 11 unsigned halve.
- bit 2 selects the lane width: 1 for 16-bit lanes, 0 for 8-bit lanes.
- bits 1:0 select the form: 00 add, 01 subtract, 10 exchange-subtract-low/add-high, 11 exchange-add-low/subtract-high.

When bit 5 is 1, a 32-bit operation is selected and bits 4:2 are ignored. Bits 1:0 then select: 00 add, 01 subtract, 10 doubling add, 11 doubling subtract.

Top module: `psh_unit`

## Requirements
- R1: After reset `res_o`, `sat_o` and `q_o` are all 0.
- R2: Signed saturating lanes (class 00) clamp each lane result to the range from -2^(w-1) to 2^(w-1)-1, where w is 8 or 16.
- R3: Unsigned saturating lanes (class 01) clamp each lane result to the range from 0 to 2^w-1. An addition that carries out gives all ones, and a subtraction that borrows gives 0.
- R4: With 16-bit lanes, form 10 makes the low half a.lo - b.hi and the high half a.hi + b.lo. Form 11 makes the low half a.lo + b.hi and the high half a.hi - b.lo. With 8-bit lanes, forms 10 and 11 behave as add and subtract.
- R5: Signed halving lanes (class 10) return bits w:1 of the sign-extended (w+1)-bit sum or difference.
- R6: Unsigned halving lanes (class 11) return bits w:1 of the zero-extended (w+1)-bit sum or difference.
- R7: Each lane is computed independently, with no carry or borrow passing between lanes.
- R8: The 32-bit add and subtract (codes 100000 and 100001) clamp the result to the signed 32-bit range, and `sat_o` shows whether clamping happened.
- R9: The doubling forms (codes 100010 and 100011) clamp 2*b to 32 bits, then clamp a plus or minus that value. `sat_o` is 1 if either step clamped.
- R10: `q_o` goes high on the edge that captures a 32-bit operation that saturated. It stays high until `clr_q_i` is sampled high in a cycle with no saturating capture. A saturating capture in the same cycle as a clear leaves `q_o` high.
- R11: Lane operations give `sat_o` = 0 and leave `q_o` unchanged.
- R12: The result of a captured operation appears on the edge after `valid_i` is sampled. While `valid_i` is low, `res_o` and `sat_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Capture an operation this cycle |
| op_i | input | 6 | Operation code (see above) |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| clr_q_i | input | 1 | Clear the sticky saturation flag |
| res_o | output | 32 | Registered packed or word result |
| sat_o | output | 1 | Registered saturation indication of the last 32-bit capture |
| q_o | output | 1 | Sticky saturation flag |

## Verification
The only state is the result register and the sticky flag. A wrong next-value term therefore shows up on `res_o` or `q_o` exactly one edge after the capture that caused it.

A lost saturation event is the hardest fault to see: `q_o` stays low, and stays low for good if no later operation saturates. For this reason the bench checks the flag after each 32-bit capture. It also checks the flag after clears, and after a clear that falls in the same cycle as a saturating capture.

A lane pairing error or a missing clamp changes only one lane of the next result. For that reason the test operands differ in every lane.

// File: rtl/psh_pkg.sv
package psh_pkg;
    localparam int DW      = 32;
    localparam int BYTE_W  = 8;
    localparam int HALF_W  = 16;
    localparam int N_BYTE  = DW / BYTE_W;
    localparam int N_HALF  = DW / HALF_W;
    localparam int OP_W    = 6;

    typedef enum logic [1:0] {
        CLS_SSAT = 2'b00,
        CLS_USAT = 2'b01,
        CLS_SHLV = 2'b10,
        CLS_UHLV = 2'b11
    } psh_cls_e;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          sat;
        logic          q;
    } psh_state_t;
endpackage

// File: rtl/psh_lane.sv
module psh_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         sub_i,
    input  logic         uns_i,
    input  logic         halve_i,
    output logic [W-1:0] z_o
);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0] ex, ey, r;

    always_comb begin
        ex = {(uns_i ? 1'b0 : x_i[W-1]), x_i};
        ey = {(uns_i ? 1'b0 : y_i[W-1]), y_i};
        r  = sub_i ? (ex - ey) : (ex + ey);
        if (halve_i) begin
            z_o = r[W:1];
        end else if (uns_i) begin
            z_o = r[W] ? (sub_i ? '0 : '1) : r[W-1:0];
        end else begin
            z_o = (r[W] != r[W-1]) ? (r[W] ? SMIN : SMAX) : r[W-1:0];
        end
    end
endmodule

// File: rtl/psh_packed.sv
module psh_packed
    import psh_pkg::*;
(
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  psh_cls_e      cls_i,
    input  logic          w16_i,
    input  logic [1:0]    form_i,
    output logic [DW-1:0] z_o
);
    logic uns, halve;
    logic [DW-1:0] zb, zh;

    assign uns   = (cls_i == CLS_USAT) || (cls_i == CLS_UHLV);
    assign halve = (cls_i == CLS_SHLV) || (cls_i == CLS_UHLV);

    for (genvar i = 0; i < N_BYTE; i++) begin : g_byte
        psh_lane #(.W(BYTE_W)) u_lane (
            .x_i    (a_i[i*BYTE_W +: BYTE_W]),
            .y_i    (b_i[i*BYTE_W +: BYTE_W]),
            .sub_i  (form_i[0]),
            .uns_i  (uns),
            .halve_i(halve),
            .z_o    (zb[i*BYTE_W +: BYTE_W])
        );
    end

    for (genvar i = 0; i < N_HALF; i++) begin : g_half
        localparam int PARTNER = N_HALF - 1 - i;
        logic          sub_h;
        logic [HALF_W-1:0] y_h;
        assign y_h   = form_i[1] ? b_i[PARTNER*HALF_W +: HALF_W]
                                 : b_i[i*HALF_W +: HALF_W];
        assign sub_h = form_i[1] ? (form_i[0] ^ (i == 0)) : form_i[0];
        psh_lane #(.W(HALF_W)) u_lane (
            .x_i    (a_i[i*HALF_W +: HALF_W]),
            .y_i    (y_h),
            .sub_i  (sub_h),
            .uns_i  (uns),
            .halve_i(halve),
            .z_o    (zh[i*HALF_W +: HALF_W])
        );
    end

    assign z_o = w16_i ? zh : zb;
endmodule

// File: rtl/psh_word.sv
module psh_word
    import psh_pkg::*;
(
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          sub_i,
    input  logic          dbl_i,
    output logic [DW-1:0] z_o,
    output logic          sat_o
);
    localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

    logic [DW:0]   dsum, fsum;
    logic [DW-1:0] dclamp, opnd;
    logic          dsat, fsat;

    always_comb begin
        dsum   = {b_i[DW-1], b_i} + {b_i[DW-1], b_i};
        dsat   = dsum[DW] != dsum[DW-1];
        dclamp = dsat ? (dsum[DW] ? SMIN : SMAX) : dsum[DW-1:0];
        opnd   = dbl_i ? dclamp : b_i;
        fsum   = sub_i ? ({a_i[DW-1], a_i} - {opnd[DW-1], opnd})
                       : ({a_i[DW-1], a_i} + {opnd[DW-1], opnd});
        fsat   = fsum[DW] != fsum[DW-1];
        z_o    = fsat ? (fsum[DW] ? SMIN : SMAX) : fsum[DW-1:0];
        sat_o  = fsat | (dbl_i & dsat);
    end
endmodule

// File: rtl/psh_unit.sv
module psh_unit
    import psh_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            valid_i,
    input  logic [OP_W-1:0] op_i,
    input  logic [DW-1:0]   a_i,
    input  logic [DW-1:0]   b_i,
    input  logic            clr_q_i,
    output logic [DW-1:0]   res_o,
    output logic            sat_o,
    output logic            q_o
);
    logic          word_sel;
    logic [DW-1:0] lane_res, word_res;
    logic          word_sat;
    psh_state_t    st_d, st_q;

    assign word_sel = op_i[5];

    psh_packed u_packed (
        .a_i   (a_i),
        .b_i   (b_i),
        .cls_i (psh_cls_e'(op_i[4:3])),
        .w16_i (op_i[2]),
        .form_i(op_i[1:0]),
        .z_o   (lane_res)
    );

    psh_word u_word (
        .a_i  (a_i),
        .b_i  (b_i),
        .sub_i(op_i[0]),
        .dbl_i(op_i[1]),
        .z_o  (word_res),
        .sat_o(word_sat)
    );

    always_comb begin
        st_d = st_q;
        if (valid_i) begin
            st_d.res = word_sel ? word_res : lane_res;
            st_d.sat = word_sel & word_sat;
        end
        if (clr_q_i) begin
            st_d.q = 1'b0;
        end
        if (valid_i && word_sel && word_sat) begin
            st_d.q = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o = st_q.res;
    assign sat_o = st_q.sat;
    assign q_o   = st_q.q;
endmodule

// File: rtl/psh_unit_chk.sv
module psh_unit_chk
    import psh_pkg::*;
(
    input logic            clk_i,
    input logic            rst_i,
    input logic            valid_i,
    input logic [OP_W-1:0] op_i,
    input logic [DW-1:0]   a_i,
    input logic [DW-1:0]   b_i,
    input logic            clr_q_i,
    input logic [DW-1:0]   res_o,
    input logic            sat_o,
    input logic            q_o
);
    // R10
    q_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (q_o && !clr_q_i) |=> q_o);

    // R10
    q_follows_sat_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(sat_o) |-> q_o);

    // R10
    q_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (clr_q_i && !(valid_i && op_i[5])) |=> !q_o);

    // R11
    lane_no_sat_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && !op_i[5]) |=> !sat_o);

    // R12
    hold_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_i |=> ($stable(res_o) && $stable(sat_o)));

    // R8
    word_pos_clamp_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && op_i == 6'b100000 && !a_i[31] && !b_i[31]) |=> !res_o[31]);
endmodule

bind psh_unit psh_unit_chk i_psh_unit_chk (.*);

// File: tb/test_psh_unit.sv
module test_psh_unit;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst;
    logic        valid;
    logic [5:0]  op;
    logic [31:0] a, b;
    logic        clr_q;
    logic [31:0] res;
    logic        sat, q;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psh_unit i_psh_unit (
        .clk_i(clk), .rst_i(rst), .valid_i(valid), .op_i(op),
        .a_i(a), .b_i(b), .clr_q_i(clr_q),
        .res_o(res), .sat_o(sat), .q_o(q)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive at negedge, capture on next posedge, sample at following negedge
    task automatic run(input logic [5:0] o, input logic [31:0] x, input logic [31:0] y,
                       input logic clr);
        op = o; a = x; b = y; valid = 1'b1; clr_q = clr;
        @(negedge clk);
        valid = 1'b0; clr_q = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 res", res, 32'h0);
        check("R1 sat", {31'b0, sat}, 32'h0);
        check("R1 q",   {31'b0, q},   32'h0);
    endtask

    task automatic t_signed_sat();
        run(6'b000000, 32'h7F8010F0, 32'h01807020, 1'b0);
        check("R2 R7 s8 add", res, 32'h7F807F10);
        run(6'b000101, 32'h80000005, 32'h00010008, 1'b0);
        check("R2 s16 sub", res, 32'h8000FFFD);
    endtask

    task automatic t_unsigned_sat();
        run(6'b001001, 32'h10FF0580, 32'h2001057F, 1'b0);
        check("R3 u8 sub", res, 32'h00FE0001);
        run(6'b001100, 32'hFFF01234, 32'h00200001, 1'b0);
        check("R3 u16 add", res, 32'hFFFF1235);
        run(6'b001000, 32'h00FF00FF, 32'h00010001, 1'b0);
        check("R7 u8 no carry", res, 32'h00FF00FF);
    endtask

    task automatic t_exchange();
        run(6'b000110, 32'h7FFF0003, 32'h00050001, 1'b0);
        check("R4 s asx", res, 32'h7FFFFFFE);
        run(6'b000111, 32'h00107FFF, 32'h00020020, 1'b0);
        check("R4 s sax", res, 32'hFFF07FFF);
        run(6'b001110, 32'hFFFF0003, 32'h00050001, 1'b0);
        check("R4 u asx", res, 32'hFFFF0000);
        run(6'b000010, 32'h01020304, 32'h10101010, 1'b0);
        check("R4 8-bit exch as add", res, 32'h11121314);
    endtask

    task automatic t_halving();
        run(6'b010000, 32'h807FFF03, 32'h807FFF04, 1'b0);
        check("R5 sh8 add", res, 32'h807FFF03);
        run(6'b010101, 32'h80000000, 32'h7FFF0001, 1'b0);
        check("R5 sh16 sub", res, 32'h8000FFFF);
        run(6'b010110, 32'h00040010, 32'h00020006, 1'b0);
        check("R5 sh asx", res, 32'h00050007);
        run(6'b011000, 32'hFF018000, 32'hFF028000, 1'b0);
        check("R6 uh8 add", res, 32'hFF018000);
        run(6'b011101, 32'h00000010, 32'h00020004, 1'b0);
        check("R6 uh16 sub", res, 32'hFFFF0006);
    endtask

    task automatic t_word();
        run(6'b100000, 32'h7FFFFFF0, 32'h00000020, 1'b0);
        check("R8 add clamp", res, 32'h7FFFFFFF);
        check("R8 add sat", {31'b0, sat}, 32'h1);
        check("R10 q set", {31'b0, q}, 32'h1);
        run(6'b100000, 32'h00000005, 32'h00000007, 1'b0);
        check("R8 add plain", res, 32'h0000000C);
        check("R8 no sat", {31'b0, sat}, 32'h0);
        check("R10 q sticky", {31'b0, q}, 32'h1);
        run(6'b000000, 32'h7F7F7F7F, 32'h01010101, 1'b0);
        check("R11 lane sat", {31'b0, sat}, 32'h0);
        check("R11 lane q", {31'b0, q}, 32'h1);
        run(6'b100001, 32'h80000000, 32'h00000001, 1'b0);
        check("R8 sub clamp", res, 32'h80000000);
        check("R8 sub sat", {31'b0, sat}, 32'h1);
    endtask

    task automatic t_clear();
        clr_q = 1'b1;
        @(negedge clk);
        clr_q = 1'b0;
        check("R10 cleared", {31'b0, q}, 32'h0);
        run(6'b100000, 32'h7FFFFFFF, 32'h00000001, 1'b1);
        check("R10 set wins", {31'b0, q}, 32'h1);
        clr_q = 1'b1;
        @(negedge clk);
        clr_q = 1'b0;
    endtask

    task automatic t_double();
        run(6'b100010, 32'hFFFFFF00, 32'h40000000, 1'b0);
        check("R9 dadd first step", res, 32'h7FFFFEFF);
        check("R9 dadd sat", {31'b0, sat}, 32'h1);
        check("R9 q", {31'b0, q}, 32'h1);
        clr_q = 1'b1;
        @(negedge clk);
        clr_q = 1'b0;
        run(6'b100011, 32'h00000010, 32'h00000008, 1'b0);
        check("R9 dsub plain", res, 32'h00000000);
        check("R9 dsub no sat", {31'b0, sat}, 32'h0);
        check("R11 q untouched", {31'b0, q}, 32'h0);
        run(6'b100011, 32'hC0000000, 32'h20000001, 1'b0);
        check("R9 dsub second step", res, 32'h80000000);
        check("R9 dsub sat", {31'b0, sat}, 32'h1);
    endtask

    task automatic t_hold();
        logic [31:0] prev;
        prev = res;
        op = 6'b000000; a = 32'h11111111; b = 32'h22222222; valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R12 hold res", res, prev);
        check("R12 hold sat", {31'b0, sat}, 32'h1);
    endtask

    initial begin
        rst = 1'b1; valid = 1'b0; clr_q = 1'b0; op = '0; a = '0; b = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_signed_sat();
        t_unsigned_sat();
        t_exchange();
        t_halving();
        t_word();
        t_clear();
        t_double();
        t_hold();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule